// File: doc/BRIEF.md
# Per-Source Interrupt Status Bank

This block holds the pending-interrupt flags of a serial port with four event sources: transmit watermark, receive watermark, transmit empty and receive overflow. The transmit and receive paths raise single-cycle pulses on `evt_pulse`. Each pulse latches a sticky status bit, and that bit stays set until software clears it. A second register masks each source. The block drives one level interrupt line per source. Each line is registered and is high when that source is both pending and unmasked.

Software sees three 32-bit word registers. The status register reads the pending flags and clears them with write-one-to-clear. The mask register is read/write. The inject register is write-only and sets pending flags exactly as hardware events do, so interrupt handlers can be tested without traffic on the serial line.

Top module: `irq_status_bank`

## Requirements
- R1: Bit positions are fixed: bit 0 transmit watermark, bit 1 receive watermark, bit 2 transmit empty, bit 3 receive overflow. A one-cycle pulse on `evt_pulse[i]` sets status bit i at the next clock edge.
- R2: Byte offset 0x0 selects the status register, 0x4 the mask register and 0x8 the inject register. Every access is a full 32-bit word. Any other offset reads zero and ignores writes.
- R3: After reset, the status register, the mask register and every `irq_out` line are zero.
- R4: A write to the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: A write to the inject register ORs the written value into the status register.
- R6: `irq_out[i]` is high exactly when status bit i and mask bit i were both set at the previous clock edge. A change in status or mask reaches the line one cycle after the register changes.
- R7: If a hardware event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R8: The inject register reads zero. Reading any register leaves the status and the mask unchanged.
- R9: Register bits at and above bit 4 read as zero, and writes to them are ignored, in all three registers.
- R10: A write to the mask register loads bits 3:0 from the written value and never changes the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one word per cycle |
| reg_rd | input | 1 | Register read strobe; `reg_rdata` is zero while it is low |
| reg_addr | input | 4 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address and register state |
| evt_pulse | input | 4 | One-cycle event pulses, bit i for source i |
| irq_out | output | 4 | Registered level interrupt, one line per source |

## Verification
A write or an event pulse presented before edge k shows in `reg_rdata` straight after edge k, because reads are combinational. The matching `irq_out` line moves only at edge k+1. The bench drives every stimulus on a falling edge and reads registers at the next falling edge. It checks each interrupt line twice: once at that falling edge, where the line must still hold its old value, and again one cycle later, where it must hold the new value. This pins the one-cycle lag to an exact cycle instead of accepting any later one.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

   // Byte offsets of the three word registers
   localparam int unsigned OFS_STATUS = 32'h0;
   localparam int unsigned OFS_MASK   = 32'h4;
   localparam int unsigned OFS_INJECT = 32'h8;

   // Source positions; a neighbour relies on this order
   localparam int unsigned SRC_TX_WMARK = 0;
   localparam int unsigned SRC_RX_WMARK = 1;
   localparam int unsigned SRC_TX_EMPTY = 2;
   localparam int unsigned SRC_RX_OVF   = 3;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_MASK   = 2'd2,
      SEL_INJECT = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
   import irq_bank_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   generate
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("irq_reg_decode: ADDR_W must cover offset 0x8");
      end
   endgenerate

   always_comb begin
      if (addr == ADDR_W'(OFS_STATUS))
         sel = SEL_STATUS;
      else if (addr == ADDR_W'(OFS_MASK))
         sel = SEL_MASK;
      else if (addr == ADDR_W'(OFS_INJECT))
         sel = SEL_INJECT;
      else
         sel = SEL_NONE;
   end

endmodule

// File: rtl/irq_state_cell.sv
module irq_state_cell #(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic set_req,
   input  logic clr_req,
   input  logic mask_wr,
   input  logic mask_wdata,
   output logic pend_q,
   output logic mask_q,
   output logic irq
);

   // Event and injection take priority over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         mask_q <= 1'b0;
      end else begin
         if (evt || set_req)
            pend_q <= 1'b1;
         else if (clr_req)
            pend_q <= 1'b0;
         if (mask_wr)
            mask_q <= mask_wdata;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               irq_q <= 1'b0;
            else
               irq_q <= pend_q & mask_q;
         end
         assign irq = irq_q;

         // R6
         masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(mask_q) |-> !irq);
         // R6
         rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq) |-> $past(pend_q && mask_q));
      end else begin : g_irq_comb
         assign irq = pend_q & mask_q;
      end
   endgenerate

   // R1
   event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> pend_q);
   // R4
   clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !evt && !set_req) |=> !pend_q);
   // R5
   inject_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> pend_q);
   // R7
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && clr_req) |=> pend_q);
   // R10
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt || set_req || clr_req) |=> $stable(pend_q));

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
   import irq_bank_pkg::*;
#(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               rd,
   input  reg_sel_e           sel,
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] mask,
   output logic [DATA_W-1:0]  rdata
);

   always_comb begin
      rdata = '0;
      if (rd) begin
         case (sel)
            SEL_STATUS: rdata[NUM_SRC-1:0] = pend;
            SEL_MASK:   rdata[NUM_SRC-1:0] = mask;
            default:    rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
   import irq_bank_pkg::*;
#(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_SRC-1:0] evt_pulse,
   output logic [NUM_SRC-1:0] irq_out
);

   localparam int unsigned SPARE_W = DATA_W - NUM_SRC;

   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_num_src
         $error("irq_status_bank: NUM_SRC must lie in 1..DATA_W");
      end
      if (SPARE_W > 0) begin : g_spare
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_SRC];
      end
   endgenerate

   reg_sel_e           sel;
   logic               wr_status;
   logic               wr_mask;
   logic               wr_inject;
   logic [NUM_SRC-1:0] pend_vec;
   logic [NUM_SRC-1:0] mask_vec;

   irq_reg_decode #(.ADDR_W(ADDR_W)) i_decode (
      .addr (reg_addr),
      .sel  (sel)
   );

   assign wr_status = reg_wr && (sel == SEL_STATUS);
   assign wr_mask   = reg_wr && (sel == SEL_MASK);
   assign wr_inject = reg_wr && (sel == SEL_INJECT);

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         irq_state_cell #(.IRQ_REG(IRQ_REG)) i_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt        (evt_pulse[i]),
            .set_req    (wr_inject && reg_wdata[i]),
            .clr_req    (wr_status && reg_wdata[i]),
            .mask_wr    (wr_mask),
            .mask_wdata (reg_wdata[i]),
            .pend_q     (pend_vec[i]),
            .mask_q     (mask_vec[i]),
            .irq        (irq_out[i])
         );
      end
   endgenerate

   irq_read_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_rmux (
      .rd    (reg_rd),
      .sel   (sel),
      .pend  (pend_vec),
      .mask  (mask_vec),
      .rdata (reg_rdata)
   );

   // R8
   read_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && evt_pulse == '0) |=> ($stable(pend_vec) && $stable(mask_vec)));
   // R10
   mask_write_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mask && evt_pulse == '0) |=> $stable(pend_vec));
   // R2
   bad_offset_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && sel == SEL_NONE && evt_pulse == '0) |=>
         ($stable(pend_vec) && $stable(mask_vec)));

endmodule

// File: tb/test_irq_status_bank.sv
`timescale 1ns/1ps
module test_irq_status_bank;

   localparam int NSRC = 4;
   localparam int DW   = 32;
   localparam int AW   = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_wr = 1'b0;
   logic            reg_rd = 1'b0;
   logic [AW-1:0]   reg_addr = '0;
   logic [DW-1:0]   reg_wdata = '0;
   logic [DW-1:0]   reg_rdata;
   logic [NSRC-1:0] evt_pulse = '0;
   logic [NSRC-1:0] irq_out;

   int n_checks = 0;
   int n_fails  = 0;
   logic [NSRC-1:0] m_pend = '0;
   logic [NSRC-1:0] m_mask = '0;

   always #2.5 clk = ~clk;

   irq_status_bank #(.NUM_SRC(NSRC), .DATA_W(DW), .ADDR_W(AW)) i_irq_status_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt_pulse (evt_pulse),
      .irq_out   (irq_out)
   );

   task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      reg_rd = 1'b1; reg_addr = a;
      #0.5;
      d = reg_rdata;
      reg_rd = 1'b0;
   endtask

   task automatic pulse(input logic [NSRC-1:0] e);
      @(negedge clk);
      evt_pulse = e;
      @(negedge clk);
      evt_pulse = '0;
   endtask

   task automatic check_regs(input string req);
      logic [DW-1:0] d;
      rd(4'h0, d); check({req, " status"}, d, DW'(m_pend));
      rd(4'h4, d); check({req, " mask"}, d, DW'(m_mask));
   endtask

   // Lag check: old value now, new value one cycle later
   task automatic check_irq_lag(input string req, input logic [NSRC-1:0] old_v);
      check({req, " irq before lag"}, DW'(irq_out), DW'(old_v));
      @(negedge clk);
      check({req, " irq after lag"}, DW'(irq_out), DW'(m_pend & m_mask));
   endtask

   task automatic t_reset;
      logic [DW-1:0] d;
      check_regs("R3");
      check("R3 irq", DW'(irq_out), '0);
      rd(4'h8, d); check("R8 inject reads zero", d, '0);
   endtask

   task automatic t_event_map;
      wr(4'h4, 32'hF); m_mask = 4'hF;
      for (int i = 0; i < NSRC; i++) begin
         pulse(NSRC'(1 << i)); m_pend = NSRC'(1 << i);
         check_regs("R1 event bit");
         check_irq_lag("R6 event", '0);
         wr(4'h0, 32'(1 << i)); m_pend = '0;
         check_regs("R4 clear after event");
         @(negedge clk);
         check("R6 irq drops", DW'(irq_out), '0);
      end
   endtask

   task automatic t_w1c;
      wr(4'h8, 32'hF); m_pend = 4'hF;
      check_regs("R5 inject all");
      wr(4'h0, 32'h5); m_pend = 4'hA;
      check_regs("R4 partial clear");
      wr(4'h0, 32'h0); check_regs("R4 zero write keeps");
      wr(4'h0, 32'hA); m_pend = 4'h0;
      check_regs("R4 clear rest");
   endtask

   task automatic t_inject;
      logic [DW-1:0] d;
      wr(4'h8, 32'h2); m_pend = 4'h2;
      check_regs("R5 inject one");
      wr(4'h8, 32'h8); m_pend = 4'hA;
      check_regs("R5 inject ORs");
      rd(4'h8, d); check("R8 inject reads zero", d, '0);
      rd(4'h0, d); rd(4'h0, d);
      @(negedge clk);
      check_regs("R8 reads leave state");
   endtask

   task automatic t_mask;
      wr(4'h4, 32'h0); m_mask = 4'h0;
      @(negedge clk);
      check("R6 masked irq low", DW'(irq_out), '0);
      wr(4'h4, 32'h2); m_mask = 4'h2;
      check_regs("R10 mask load keeps status");
      check_irq_lag("R6 unmask", '0);
      wr(4'h4, 32'h0); m_mask = 4'h0;
      check_irq_lag("R6 remask", 4'h2);
      wr(4'h0, 32'hF); m_pend = '0;
   endtask

   task automatic t_priority;
      wr(4'h4, 32'hF); m_mask = 4'hF;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h8; evt_pulse = 4'h8;
      @(negedge clk);
      reg_wr = 1'b0; evt_pulse = '0; m_pend = 4'h8;
      check_regs("R7 event beats clear");
      wr(4'h8, 32'h1); m_pend = 4'h9;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h1; evt_pulse = 4'h2;
      @(negedge clk);
      reg_wr = 1'b0; evt_pulse = '0; m_pend = 4'hA;
      check_regs("R7 other bit cleared");
      @(negedge clk);
      check("R6 irq after mix", DW'(irq_out), 32'hA);
      wr(4'h0, 32'hF); m_pend = '0;
   endtask

   task automatic t_upper;
      logic [DW-1:0] d;
      wr(4'h4, 32'hFFFF_FFF5); m_mask = 4'h5;
      rd(4'h4, d); check("R9 mask upper zero", d, 32'h5);
      wr(4'h8, 32'hFFFF_FFF0);
      rd(4'h0, d); check("R9 inject upper ignored", d, 32'h0);
      wr(4'h0, 32'hFFFF_FFF0);
      check_regs("R9 clear upper ignored");
   endtask

   task automatic t_offset;
      logic [DW-1:0] d;
      wr(4'hC, 32'hF);
      rd(4'hC, d); check("R2 unused offset reads zero", d, '0);
      check_regs("R2 unused offset write ignored");
      wr(4'h2, 32'hF);
      check_regs("R2 unaligned offset ignored");
   endtask

   initial begin : watchdog
      #(5.0 * 100000);
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_event_map();
      t_w1c();
      t_inject();
      t_mask();
      t_priority();
      t_upper();
      t_offset();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule